// File: doc/BRIEF.md
# Multi-channel capture/compare timer

A bank of identical up-counting timer channels, each with a counter and two general registers, A and B. A channel counts a gated system clock or the rising edges of its own event input. Its counter can run free, wrapping at the top of its range, or be cleared by a match on A or on B so that it counts a fixed period. Each general register either captures the counter on an edge of a capture input or compares against the counter and drives an output pin on a match.

Channels marked as members of the sync group share counter writes and clears. A write to the counter of one member loads every member in the same cycle. A member whose clear source is set to sync clears whenever another member clears from its own match. A per-channel PWM mode sets output A on match A and clears it on match B. This gives a two-edge waveform whose duty cycle runs from 0% to 100%.

Software reaches every register through a flat write strobe and a combinational read port. Each channel has four words at address `ch*4 + n`.

Top module: `cc_timer_top`

## Requirements
- R1: After reset every register (control, counter, A, B) of every channel reads zero, and every output pin is low.
- R2: A channel with control bit 2 (run) set and bit 3 (ext) clear adds one to its counter on every clock with `clk_en_i` high. 16'hFFFF wraps to 0. With run clear the counter holds.
- R3: Control bits [1:0] select the clear source. 00 means none, 01 means match A, 10 means match B and 11 means sync. A match fires on a tick where the counter equals the register, so clearing on a value V gives a period of V+1 ticks.
- R4: When a compare match and a clear fall on the same tick, the output change takes effect on that tick and the counter goes to 0 instead of V+1.
- R5: Outside PWM mode, a compare match on A toggles `out_a_o` and a compare match on B toggles `out_b_o`.
- R6: With control bit 3 (ext) set, the counter advances once per rising edge of `evt_i`, sampled through a two-flop synchronizer, and `clk_en_i` has no effect.
- R7: Control bit 4 (A) or bit 5 (B) makes that register capture. Bit 6 (A) or bit 7 (B) picks the falling edge instead of the rising edge. On the chosen edge of the capture input the register loads the counter three clocks after the input changes, and the other edge leaves it unchanged.
- R8: A counter write to a channel with control bit 9 (sync) set loads the same value into every sync channel in that cycle. Non-members are left alone.
- R9: A sync member with clear select 11 clears on the tick on which any other member clears from its own A or B match.
- R10: Control bit 8 (pwm) makes A and B compare registers regardless of bits 4 and 5. In that mode `out_a_o` goes high on match A and low on match B.
- R11: In PWM mode, when A and B match on the same tick, the output goes high. With clear on B, A equal to B gives a 100% duty cycle and A above B gives 0%.
- R12: Word offsets are 0 control, 1 counter, 2 A and 3 B. The control register keeps bits [9:0] and reads zero above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_en_i | input | 1 | Count enable for internally clocked channels |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW (3) | Word address, channel in upper bits, register in [1:0] |
| wdata_i | input | W (16) | Write data |
| rdata_o | output | W (16) | Read data for addr_i, combinational |
| cap_a_i | input | NCH (2) | Capture inputs for register A, one per channel |
| cap_b_i | input | NCH (2) | Capture inputs for register B, one per channel |
| evt_i | input | NCH (2) | External count event inputs |
| out_a_o | output | NCH (2) | Compare/PWM outputs A |
| out_b_o | output | NCH (2) | Compare outputs B |

## Verification
Counter, compare and clear effects are due on the clock edge that carries the qualifying tick. The bench drives `clk_en_i` across an exact number of edges and reads the counter and pins half a cycle later. Captures and event counts pass through two synchronizer flops and an edge flop, so a capture is due on the third edge after the input changes. The bench times one capture against a running counter and expects the count of that third edge. Register writes and sync loads land on the edge after the strobe, and reads are combinational, so every read is sampled just after a falling edge.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  localparam int CTRL_W = 10;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_ON_A = 2'b01,
    CLR_ON_B = 2'b10,
    CLR_SYNC = 2'b11
  } clr_sel_e;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CNT  = 2'd1,
    REG_A    = 2'd2,
    REG_B    = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     sync;
    logic     pwm;
    logic     b_fall;
    logic     a_fall;
    logic     b_cap;
    logic     a_cap;
    logic     ext_evt;
    logic     run;
    clr_sel_e clr_sel;
  } ch_ctrl_t;
endpackage

// File: rtl/cc_sync_edge.sv
module cc_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], d_i};
  end

  assign rise_o = sh_q[1] & ~sh_q[2];
  assign fall_o = ~sh_q[1] & sh_q[2];
endmodule

// File: rtl/cc_channel.sv
module cc_channel
  import cc_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clk_en_i,
  input  ch_ctrl_t     ctrl_i,
  input  logic         ld_cnt_i,
  input  logic         wr_a_i,
  input  logic         wr_b_i,
  input  logic [W-1:0] wdata_i,
  input  logic         cap_a_i,
  input  logic         cap_b_i,
  input  logic         evt_i,
  input  logic         sync_clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] ra_o,
  output logic [W-1:0] rb_o,
  output logic         tick_o,
  output logic         mat_a_o,
  output logic         mat_b_o,
  output logic         own_clr_o,
  output logic         clr_o,
  output logic         out_a_o,
  output logic         out_b_o
);
  logic a_rise, a_fall, b_rise, b_fall, e_rise, e_fall;
  logic [W-1:0] cnt_q, ra_q, rb_q;
  logic out_a_q, out_b_q;
  logic cmp_a, cmp_b, cap_a_hit, cap_b_hit;

  cc_sync_edge u_sync_a (.clk_i, .rst_ni, .d_i(cap_a_i), .rise_o(a_rise), .fall_o(a_fall));
  cc_sync_edge u_sync_b (.clk_i, .rst_ni, .d_i(cap_b_i), .rise_o(b_rise), .fall_o(b_fall));
  cc_sync_edge u_sync_e (.clk_i, .rst_ni, .d_i(evt_i),   .rise_o(e_rise), .fall_o(e_fall));

  // pwm forces both registers to compare
  assign cmp_a = ctrl_i.pwm | ~ctrl_i.a_cap;
  assign cmp_b = ctrl_i.pwm | ~ctrl_i.b_cap;

  assign tick_o  = ctrl_i.run & (ctrl_i.ext_evt ? e_rise : clk_en_i);
  assign mat_a_o = tick_o & cmp_a & (cnt_q == ra_q);
  assign mat_b_o = tick_o & cmp_b & (cnt_q == rb_q);

  assign own_clr_o = (ctrl_i.clr_sel == CLR_ON_A && mat_a_o) ||
                     (ctrl_i.clr_sel == CLR_ON_B && mat_b_o);
  assign clr_o = own_clr_o | (ctrl_i.sync & (ctrl_i.clr_sel == CLR_SYNC) & sync_clr_i);

  assign cap_a_hit = ~cmp_a & (ctrl_i.a_fall ? a_fall : a_rise);
  assign cap_b_hit = ~cmp_b & (ctrl_i.b_fall ? b_fall : b_rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (ld_cnt_i) begin
      cnt_q <= wdata_i;
    end else if (clr_o) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ra_q <= '0;
      rb_q <= '0;
    end else begin
      if (cap_a_hit)   ra_q <= cnt_q;
      else if (wr_a_i) ra_q <= wdata_i;
      if (cap_b_hit)   rb_q <= cnt_q;
      else if (wr_b_i) rb_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_a_q <= 1'b0;
      out_b_q <= 1'b0;
    end else if (ctrl_i.pwm) begin
      // set has priority: equal A and B give full duty
      if (mat_a_o)      out_a_q <= 1'b1;
      else if (mat_b_o) out_a_q <= 1'b0;
    end else begin
      if (mat_a_o) out_a_q <= ~out_a_q;
      if (mat_b_o) out_b_q <= ~out_b_q;
    end
  end

  assign cnt_o   = cnt_q;
  assign ra_o    = ra_q;
  assign rb_o    = rb_q;
  assign out_a_o = out_a_q;
  assign out_b_o = out_b_q;
endmodule

// File: rtl/cc_timer_top.sv
module cc_timer_top
  import cc_timer_pkg::*;
#(
  parameter int NCH = 2,
  parameter int W   = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = CHW + 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clk_en_i,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [W-1:0]   wdata_i,
  output logic [W-1:0]   rdata_o,
  input  logic [NCH-1:0] cap_a_i,
  input  logic [NCH-1:0] cap_b_i,
  input  logic [NCH-1:0] evt_i,
  output logic [NCH-1:0] out_a_o,
  output logic [NCH-1:0] out_b_o
);
  logic [CHW-1:0] ch_idx;
  reg_sel_e       reg_sel;
  ch_ctrl_t       ctrl_q [NCH];

  logic [NCH-1:0][W-1:0] cnt_w, ra_w, rb_w;
  logic [NCH-1:0] cnt_hit_w, sync_mask_w, ld_w, tick_w, mat_a_w, mat_b_w;
  logic [NCH-1:0] own_clr_w, clr_w, pwm_w;
  logic sync_wr, sync_clr;

  assign ch_idx  = addr_i[AW-1:2];
  assign reg_sel = reg_sel_e'(addr_i[1:0]);

  assign sync_wr  = |(cnt_hit_w & sync_mask_w);
  assign sync_clr = |(own_clr_w & sync_mask_w);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit            = wr_en_i & (ch_idx == CHW'(g));
    assign cnt_hit_w[g]   = hit & (reg_sel == REG_CNT);
    assign sync_mask_w[g] = ctrl_q[g].sync;
    assign pwm_w[g]       = ctrl_q[g].pwm;
    assign ld_w[g]        = cnt_hit_w[g] | (sync_wr & ctrl_q[g].sync);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            ctrl_q[g] <= '0;
      else if (hit && reg_sel == REG_CTRL)    ctrl_q[g] <= ch_ctrl_t'(wdata_i[CTRL_W-1:0]);
    end

    cc_channel #(.W(W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clk_en_i   (clk_en_i),
      .ctrl_i     (ctrl_q[g]),
      .ld_cnt_i   (ld_w[g]),
      .wr_a_i     (hit & (reg_sel == REG_A)),
      .wr_b_i     (hit & (reg_sel == REG_B)),
      .wdata_i    (wdata_i),
      .cap_a_i    (cap_a_i[g]),
      .cap_b_i    (cap_b_i[g]),
      .evt_i      (evt_i[g]),
      .sync_clr_i (sync_clr),
      .cnt_o      (cnt_w[g]),
      .ra_o       (ra_w[g]),
      .rb_o       (rb_w[g]),
      .tick_o     (tick_w[g]),
      .mat_a_o    (mat_a_w[g]),
      .mat_b_o    (mat_b_w[g]),
      .own_clr_o  (own_clr_w[g]),
      .clr_o      (clr_w[g]),
      .out_a_o    (out_a_o[g]),
      .out_b_o    (out_b_o[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_idx == CHW'(i)) begin
        unique case (reg_sel)
          REG_CTRL: rdata_o = W'(ctrl_q[i]);
          REG_CNT:  rdata_o = cnt_w[i];
          REG_A:    rdata_o = ra_w[i];
          REG_B:    rdata_o = rb_w[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
  parameter int NCH = 2,
  parameter int W   = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NCH-1:0][W-1:0] cnt_i,
  input logic [NCH-1:0]        tick_i,
  input logic [NCH-1:0]        ld_i,
  input logic [NCH-1:0]        clr_i,
  input logic [NCH-1:0]        mat_a_i,
  input logic [NCH-1:0]        mat_b_i,
  input logic [NCH-1:0]        pwm_i,
  input logic [NCH-1:0]        out_a_i,
  input logic [NCH-1:0]        out_b_i
);
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i[g] && !ld_i[g] && !clr_i[g] |=> cnt_i[g] == W'($past(cnt_i[g]) + 1'b1)); // R2
    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i[g] && !ld_i[g] && !clr_i[g] |=> $stable(cnt_i[g])); // R2
    AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[g] && !ld_i[g] |=> cnt_i[g] == '0); // R3
    AST_SYNC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_i[0] && ld_i[g] |=> cnt_i[g] == cnt_i[0]); // R8
    AST_PWM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwm_i[g] && mat_a_i[g] |=> out_a_i[g]); // R11
    AST_PWM_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwm_i[g] && mat_b_i[g] && !mat_a_i[g] |=> !out_a_i[g]); // R10
    AST_CMP_TOGGLE_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwm_i[g] && mat_b_i[g] |=> out_b_i[g] != $past(out_b_i[g])); // R5
  end
endmodule

bind cc_timer_top cc_timer_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cnt_i   (cnt_w),
  .tick_i  (tick_w),
  .ld_i    (ld_w),
  .clr_i   (clr_w),
  .mat_a_i (mat_a_w),
  .mat_b_i (mat_b_w),
  .pwm_i   (pwm_w),
  .out_a_i (out_a_o),
  .out_b_i (out_b_o)
);

// File: tb/cc_timer_top_bench.sv
module cc_timer_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0] cap_a = '0, cap_b = '0, evt = '0;
  logic [1:0] out_a, out_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cc_timer_top u_cc_timer_top (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(clk_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .cap_a_i(cap_a), .cap_b_i(cap_b), .evt_i(evt),
    .out_a_o(out_a), .out_b_o(out_b)
  );

  localparam int O_CTRL = 0, O_CNT = 1, O_A = 2, O_B = 3;
  localparam logic [15:0] C_RUN = 16'h0004, C_EXT = 16'h0008, C_ACAP = 16'h0010,
                          C_BCAP = 16'h0020, C_BFALL = 16'h0080, C_PWM = 16'h0100,
                          C_SYNC = 16'h0200;

  // vector table: start, clear select, A, B, run, ticks, expected count
  localparam int NV = 6;
  localparam logic [15:0] V_START [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hFFFE, 16'h0040};
  localparam logic [15:0] V_CLR   [NV] = '{16'd0, 16'd1, 16'd2, 16'd1, 16'd0, 16'd0};
  localparam logic [15:0] V_A     [NV] = '{16'd5, 16'd5, 16'd50, 16'd0, 16'd5, 16'd5};
  localparam logic [15:0] V_B     [NV] = '{16'd100, 16'd100, 16'd3, 16'd100, 16'd100, 16'd100};
  localparam logic        V_RUN   [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam int          V_TICKS [NV] = '{10, 10, 10, 7, 3, 5};
  localparam logic [15:0] V_EXP   [NV] = '{16'd10, 16'd4, 16'd2, 16'd0, 16'h0001, 16'h0040};

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int ch, input int off, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(ch * 4 + off); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input int off, output logic [15:0] d);
    @(negedge clk);
    addr = 3'(ch * 4 + off);
    #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      clk_en = 1'b1;
      repeat (n) @(negedge clk);
      clk_en = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [15:0] d, d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int ch = 0; ch < 2; ch++)
      for (int off = 0; off < 4; off++) begin
        rd(ch, off, d);
        chk("R1 reset register", d, 16'h0000);
      end
    chk("R1 reset outputs", {12'b0, out_a, out_b}, 16'h0000);

    // R12 control field width
    wr(1, O_CTRL, 16'hFFFF);
    rd(1, O_CTRL, d);
    chk("R12 ctrl readback", d, 16'h03FF);
    wr(1, O_CTRL, 16'h0000);

    // R2 R3 vector walk on channel 0
    for (int v = 0; v < NV; v++) begin
      wr(0, O_A, V_A[v]);
      wr(0, O_B, V_B[v]);
      wr(0, O_CTRL, (V_RUN[v] ? C_RUN : 16'h0) | V_CLR[v]);
      wr(0, O_CNT, V_START[v]);
      ticks(V_TICKS[v]);
      rd(0, O_CNT, d);
      chk($sformatf("R2/R3 vector %0d", v), d, V_EXP[v]);
    end
    rd(0, O_A, d);
    chk("R12 A readback", d, 16'd5);

    // R4 R5 on channel 1, outputs low since reset
    wr(1, O_A, 16'd2);
    wr(1, O_B, 16'd1);
    wr(1, O_CTRL, C_RUN | 16'd1);
    wr(1, O_CNT, 16'd0);
    ticks(2);
    chk("R5 B toggled high", {15'b0, out_b[1]}, 16'd1);
    chk("R5 A not yet", {15'b0, out_a[1]}, 16'd0);
    ticks(1);
    rd(1, O_CNT, d);
    chk("R4 wrap to zero on match", d, 16'd0);
    chk("R4 output on clearing tick", {15'b0, out_a[1]}, 16'd1);
    ticks(3);
    chk("R5 A toggled back", {15'b0, out_a[1]}, 16'd0);
    chk("R5 B toggled back", {15'b0, out_b[1]}, 16'd0);

    // R10 PWM on channel 0, capture bit set but forced to compare
    wr(0, O_A, 16'd2);
    wr(0, O_B, 16'd5);
    wr(0, O_CTRL, C_RUN | C_PWM | C_ACAP | 16'd2);
    wr(0, O_CNT, 16'd0);
    ticks(3);
    chk("R10 pwm set on A", {15'b0, out_a[0]}, 16'd1);
    ticks(3);
    chk("R10 pwm clear on B", {15'b0, out_a[0]}, 16'd0);
    rd(0, O_CNT, d);
    chk("R10 period restart", d, 16'd0);
    ticks(2);
    chk("R10 low before A", {15'b0, out_a[0]}, 16'd0);
    ticks(1);
    chk("R10 high again", {15'b0, out_a[0]}, 16'd1);

    // R11 duty extremes
    wr(0, O_A, 16'd3);
    wr(0, O_B, 16'd3);
    wr(0, O_CNT, 16'd0);
    ticks(4);
    chk("R11 full duty first", {15'b0, out_a[0]}, 16'd1);
    ticks(6);
    chk("R11 full duty held", {15'b0, out_a[0]}, 16'd1);
    wr(0, O_A, 16'd6);
    wr(0, O_CNT, 16'd0);
    ticks(4);
    chk("R11 zero duty low", {15'b0, out_a[0]}, 16'd0);
    ticks(8);
    chk("R11 zero duty held", {15'b0, out_a[0]}, 16'd0);

    // R7 capture latency against running counter
    wr(1, O_CTRL, C_RUN | C_ACAP);
    @(negedge clk);
    clk_en = 1'b1; wr_en = 1'b1; addr = 3'(4 + O_CNT); wdata = 16'd0;
    @(negedge clk);
    wr_en = 1'b0; cap_a[1] = 1'b1;
    repeat (4) @(negedge clk);
    clk_en = 1'b0;
    rd(1, O_A, d);
    chk("R7 capture on third edge", d, 16'd2);

    // R7 falling-edge select on B
    wr(1, O_CTRL, C_RUN | C_BCAP | C_BFALL);
    wr(1, O_CNT, 16'h0777);
    @(negedge clk); cap_b[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd(1, O_B, d);
    chk("R7 rising edge ignored", d, 16'd1);
    @(negedge clk); cap_b[1] = 1'b0;
    repeat (5) @(negedge clk);
    rd(1, O_B, d);
    chk("R7 falling edge capture", d, 16'h0777);

    // R8 sync write
    wr(0, O_CTRL, C_RUN | C_SYNC);
    wr(1, O_CTRL, C_RUN | C_SYNC);
    wr(1, O_CNT, 16'h0100);
    rd(0, O_CNT, d);
    rd(1, O_CNT, d2);
    chk("R8 sync load ch0", d, 16'h0100);
    chk("R8 sync load ch1", d2, 16'h0100);

    // R9 sync clear
    wr(0, O_A, 16'd3);
    wr(0, O_CTRL, C_RUN | C_SYNC | 16'd1);
    wr(1, O_CTRL, C_RUN | C_SYNC | 16'd3);
    wr(0, O_CNT, 16'd0);
    ticks(4);
    rd(1, O_CNT, d);
    chk("R9 follower cleared", d, 16'd0);
    ticks(2);
    rd(1, O_CNT, d);
    chk("R9 follower counts on", d, 16'd2);

    // R8 non-member untouched
    wr(1, O_CTRL, C_RUN);
    wr(0, O_CNT, 16'h0055);
    rd(1, O_CNT, d);
    chk("R8 non-member kept", d, 16'd2);

    // R6 external events, clk_en held high throughout
    wr(1, O_CTRL, C_RUN | C_EXT);
    wr(1, O_CNT, 16'd0);
    @(negedge clk); clk_en = 1'b1;
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); evt[1] = 1'b1;
      repeat (3) @(negedge clk);
      evt[1] = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    clk_en = 1'b0;
    rd(1, O_CNT, d);
    chk("R6 event count", d, 16'd3);

    done = 1'b1;
    finish_run();
  end
endmodule